// File: doc/BRIEF.md
# Serial Control Register Port

This block receives 16-bit write frames on a three-wire serial link (active-low enable, serial clock, serial data) and keeps a bank of ten 12-bit control registers, whose contents are presented as one flat parallel bus. There is no readback path. The serial lines are oversampled on the system clock through two-flop synchronizers, and their edges are found in that domain. As a result, every register update happens on the system clock. The system clock must run fast enough that each serial level is held for at least three of its cycles.

A frame opens when the enable line falls. It carries the register address first, then the data, most significant bit first. The frame commits only when the enable line rises after exactly sixteen serial clock pulses. A shorter frame is dropped. Pulses after the sixteenth are not shifted in. The active-low power-on reset forces every register to its default value for as long as it is held low.

Top module: `serial_regport`

## Requirements
- R1: While por_n is low, every register holds its default value (register 4 = 12'h07C, all others 12'h000), and the defaults remain after por_n is released.
- R2: While sen_n is low, sdata is captured on each rising sclk edge, MSB first. Bits 15..12 of the frame form the address and bits 11..0 form the data. A complete frame is written when sen_n rises and appears on regs_o by the third clk edge after that rise. Each rise of sen_n writes at most once.
- R3: Register i occupies regs_o[12*i+11 : 12*i]. A frame changes only the addressed register.
- R4: A frame with fewer than 16 sclk rising edges changes no register.
- R5: sclk edges after the sixteenth are ignored, so a long frame writes the value carried by its first 16 bits.
- R6: Frames addressed to 10 through 15 complete normally but change no register.
- R7: No register changes while sen_n stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the serial lines |
| por_n | input | 1 | Active-low power-on reset; loads the register defaults |
| sen_n | input | 1 | Active-low frame enable |
| sclk | input | 1 | Serial clock; data is taken on its rising edge |
| sdata | input | 1 | Serial data, MSB first |
| regs_o | output | 120 | Contents of the ten 12-bit registers, register 0 in the low bits |

## Verification
Random frames with random addresses are mixed with directed ones.

- Exact 16-bit frames show that the address and data land in the right slice, in MSB-first order.
- Frames of 1 to 15 bits show that incomplete transfers are discarded.
- Frames of 17 to 24 bits, with random trailing bits, show that the bit counter stops capturing at sixteen.
- Frames to addresses 10 through 15 must leave the whole bank unchanged.
- The registers are also compared in the middle of a complete frame, before the enable line rises, to show that nothing is written before the commit.
- A reset in the middle of the run must restore the defaults over values written earlier.

// File: rtl/serial_regport.sv
module serial_regport #(
  parameter int ADDR_W      = 4,
  parameter int DATA_W      = 12,
  parameter int NUM_REGS    = 10,
  parameter int SYNC_STAGES = 2,
  parameter logic [NUM_REGS*DATA_W-1:0] RST_VAL = {60'h0, 12'h07C, 48'h0}
) (
  input  logic                       clk,
  input  logic                       por_n,
  input  logic                       sen_n,
  input  logic                       sclk,
  input  logic                       sdata,
  output logic [NUM_REGS*DATA_W-1:0] regs_o
);
  localparam int FRAME_W = ADDR_W + DATA_W;
  localparam int CNT_W   = $clog2(FRAME_W + 1);
  localparam int S       = SYNC_STAGES;

  logic [S:0]          sclk_p, sen_p, sdat_p;
  logic [CNT_W-1:0]    bit_cnt;
  logic [FRAME_W-1:0]  shreg;
  logic [DATA_W-1:0]   bank [NUM_REGS];

  always_ff @(posedge clk or negedge por_n)
    if (!por_n) begin
      sclk_p <= '0;
      sen_p  <= '1;
      sdat_p <= '0;
    end else begin
      sclk_p <= {sclk_p[S-1:0], sclk};
      sen_p  <= {sen_p[S-1:0], sen_n};
      sdat_p <= {sdat_p[S-1:0], sdata};
    end

  wire sclk_rise = sclk_p[S-1] & ~sclk_p[S];
  wire in_frame  = ~sen_p[S-1];
  wire sen_rise  = sen_p[S-1] & ~sen_p[S];
  wire frame_ok  = sen_rise && (bit_cnt == CNT_W'(FRAME_W));
  wire [ADDR_W-1:0] waddr = shreg[FRAME_W-1 -: ADDR_W];
  wire [DATA_W-1:0] wdata = shreg[DATA_W-1:0];

  always_ff @(posedge clk or negedge por_n)
    if (!por_n) begin
      bit_cnt <= '0;
      shreg   <= '0;
    end else if (!in_frame) begin
      bit_cnt <= '0;
    end else if (sclk_rise && bit_cnt != CNT_W'(FRAME_W)) begin
      shreg   <= {shreg[FRAME_W-2:0], sdat_p[S-1]};
      bit_cnt <= bit_cnt + 1'b1;
    end

  always_ff @(posedge clk or negedge por_n)
    if (!por_n) begin
      for (int i = 0; i < NUM_REGS; i++) bank[i] <= RST_VAL[i*DATA_W +: DATA_W];
    end else if (frame_ok) begin
      for (int i = 0; i < NUM_REGS; i++)
        if (waddr == ADDR_W'(i)) bank[i] <= wdata;
    end

  always_comb
    for (int i = 0; i < NUM_REGS; i++) regs_o[i*DATA_W +: DATA_W] = bank[i];
endmodule

// File: rtl/serial_regport_chk.sv
module serial_regport_chk #(
  parameter int DATA_W   = 12,
  parameter int NUM_REGS = 10,
  parameter logic [NUM_REGS*DATA_W-1:0] RST_VAL = '0
) (
  input logic                       clk,
  input logic                       por_n,
  input logic                       sen_n,
  input logic [NUM_REGS*DATA_W-1:0] regs_o
);
  logic [NUM_REGS*DATA_W-1:0] prev;
  logic [NUM_REGS-1:0]        chg;
  logic [1:0]                 low_cnt = '0;

  always_ff @(posedge clk) begin
    prev    <= regs_o;
    low_cnt <= por_n ? 2'd0 : (low_cnt == 2'd2 ? 2'd2 : low_cnt + 2'd1);
  end

  always_comb
    for (int i = 0; i < NUM_REGS; i++)
      chg[i] = prev[i*DATA_W +: DATA_W] != regs_o[i*DATA_W +: DATA_W];

  AST_RESET_DEFAULTS: assert property (@(posedge clk)
    (low_cnt == 2'd2 && !por_n) |-> regs_o == RST_VAL); // R1

  AST_WRITE_AFTER_RISE: assert property (@(posedge clk) disable iff (!por_n)
    (chg != '0) |-> ($past(sen_n) && $past(sen_n, 2))); // R2

  AST_SINGLE_COMMIT: assert property (@(posedge clk) disable iff (!por_n)
    (sen_n && $past(sen_n) && $past(sen_n, 2) && $past(sen_n, 3) && $past(sen_n, 4))
      |-> (chg == '0)); // R2

  AST_ONE_REG_CHANGES: assert property (@(posedge clk) disable iff (!por_n)
    $countones(chg) <= 1); // R3

  AST_QUIET_IN_FRAME: assert property (@(posedge clk) disable iff (!por_n)
    (!sen_n && !$past(sen_n) && !$past(sen_n, 2) && !$past(sen_n, 3))
      |-> (chg == '0)); // R7
endmodule

bind serial_regport serial_regport_chk #(
  .DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .RST_VAL(RST_VAL)
) u_chk (
  .clk(clk), .por_n(por_n), .sen_n(sen_n), .regs_o(regs_o)
);

// File: tb/tb_serial_regport.sv
module tb_serial_regport;
  localparam int CLK_PERIOD = 10;
  localparam int NREG = 10;
  localparam int DW   = 12;

  logic clk = 1'b0;
  logic por_n = 1'b0;
  logic sen_n = 1'b1;
  logic sclk = 1'b0;
  logic sdata = 1'b0;
  logic [NREG*DW-1:0] regs_o;

  int checks = 0;
  int fails  = 0;
  logic [DW-1:0] expv [NREG];

  serial_regport dut (
    .clk(clk), .por_n(por_n), .sen_n(sen_n), .sclk(sclk), .sdata(sdata), .regs_o(regs_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [DW-1:0] def_val(input int i);
    return (i == 4) ? 12'h07C : 12'h000;
  endfunction

  function automatic logic [NREG*DW-1:0] exp_vec();
    logic [NREG*DW-1:0] v;
    for (int i = 0; i < NREG; i++) v[i*DW +: DW] = expv[i];
    return v;
  endfunction

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag);
    checks++;
    if (regs_o !== exp_vec()) begin
      fails++;
      $display("FAIL %s: regs actual %h expected %h", tag, regs_o, exp_vec());
    end
  endtask

  task automatic load_defaults();
    for (int i = 0; i < NREG; i++) expv[i] = def_val(i);
  endtask

  task automatic send(input logic [3:0] a, input logic [11:0] d, input int nbits,
                      input bit peek, input string tag);
    logic [15:0] f = {a, d};
    sen_n = 1'b0;
    tick(3);
    for (int b = 0; b < nbits; b++) begin
      sdata = (b < 16) ? f[15-b] : 1'($urandom);
      tick(3);
      sclk = 1'b1;
      tick(3);
      sclk = 1'b0;
    end
    tick(3);
    if (peek) check("R7 before enable rise");
    sen_n = 1'b1;
    tick(6);
    if (nbits >= 16 && a < 4'd10) expv[a] = d;
    check(tag);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    load_defaults();
    tick(3);
    check("R1 held in reset");
    por_n = 1'b1;
    tick(4);
    check("R1 after release");

    send(4'd0, 12'hA5C, 16, 1'b0, "R2 reg0");
    send(4'd9, 12'hFFF, 16, 1'b0, "R3 reg9 all ones");
    send(4'd4, 12'h001, 16, 1'b1, "R2 R3 reg4 default overwritten");
    send(4'd3, 12'h123, 15, 1'b0, "R4 fifteen bits");
    send(4'd5, 12'h777, 1, 1'b0, "R4 one bit");
    send(4'd6, 12'h3C9, 20, 1'b0, "R5 twenty bits");
    send(4'd10, 12'hBAD, 16, 1'b0, "R6 address 10");
    send(4'd15, 12'hBAD, 16, 1'b0, "R6 address 15");
    send(4'd7, 12'h800, 16, 1'b1, "R7 reg7");

    for (int k = 0; k < 80; k++) begin
      int r = $urandom_range(0, 9);
      logic [3:0] a = 4'($urandom_range(0, 15));
      logic [11:0] d = 12'($urandom);
      int n = (r < 6) ? 16 : (r < 8) ? $urandom_range(1, 15) : $urandom_range(17, 24);
      string tag = (n < 16) ? "R4 random short" : (n > 16) ? "R5 random long" :
                   (a >= 4'd10) ? "R6 random unused" : "R2 R3 random full";
      send(a, d, n, (k % 10) == 0, tag);
    end

    por_n = 1'b0;
    load_defaults();
    tick(2);
    check("R1 mid-run reset");
    por_n = 1'b1;
    tick(4);
    check("R1 after second release");
    send(4'd1, 12'h5A5, 16, 1'b0, "R2 after reset");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule